// File: doc/BRIEF.md
# Write-Posting FIFO Engine

This block sits in front of an external memory controller's write path. A host pushes bytes one at a time into a posting FIFO, which holds 64 bytes by default. Once the host starts the engine with a transfer count, it drains stored bytes in arrival order through a ready/valid drain port. That port stands in for the memory-device write timing. Every stored byte goes out; there are no byte enables.

While the engine runs, it reports three things: how many byte slots are free, whether that free space has reached a programmable threshold, and how many bytes are still to be posted. It decrements the posting count once for each byte handed to the drain port. When the count reaches zero, the engine drops back to idle by itself.

Two sticky status bits, each with its own enable, record events: a FIFO-space event and a terminal-count event. Software clears either bit by pulsing its clear input. A single interrupt line merges both enabled bits.

Top module: `wpost_engine`

## Requirements
- R1: `free_slots` equals DEPTH minus the number of stored bytes. After reset it reads DEPTH (64) and it never exceeds DEPTH.
- R2: `thresh_hit` is high exactly when `free_slots` is greater than or equal to `thresh`.
- R3: A push while the FIFO is full is dropped and sets the sticky `overflow` flag. An accepted start clears `overflow`.
- R4: A `start` pulse while idle with a nonzero `xfer_count` raises `active` on the next cycle and loads `remaining` with `xfer_count`. A `start` with a zero count, or a `start` while already active, is ignored.
- R5: `remaining` decrements by one for each byte accepted at the drain port, and reads zero whenever `active` is low.
- R6: `drain_valid` is high only while `active` is high and the FIFO holds data. Bytes leave in push order, and every pushed byte is delivered.
- R7: When `remaining` reaches zero, `active` falls on the same edge. Any bytes still stored stay in the FIFO.
- R8: The terminal-count status `tc_ev_st` sets on that automatic completion only if `tc_ev_en` is high. It stays set until `tc_ev_clr` is pulsed.
- R9: `fifo_ev_st` sets on every cycle in which `fifo_ev_en` and `thresh_hit` are both high. A `fifo_ev_clr` pulse has no effect while that condition still holds. Otherwise the clear drops the bit and the bit then stays clear.
- R10: `irq` is high exactly when (`fifo_ev_st` and `fifo_ev_en`) or (`tc_ev_st` and `tc_ev_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Host byte write strobe |
| push_data | input | 8 | Host byte |
| start | input | 1 | Start pulse |
| xfer_count | input | 14 | Bytes to post for this run |
| thresh | input | 7 | Free-space threshold |
| fifo_ev_en | input | 1 | FIFO-space event enable |
| fifo_ev_clr | input | 1 | Clear pulse for FIFO-space status |
| tc_ev_en | input | 1 | Terminal-count event enable |
| tc_ev_clr | input | 1 | Clear pulse for terminal-count status |
| drain_ready | input | 1 | Memory side accepts a byte |
| drain_valid | output | 1 | Byte available to memory side |
| drain_data | output | 8 | Byte to memory side |
| free_slots | output | 7 | Free byte slots |
| thresh_hit | output | 1 | Free slots at or above threshold |
| remaining | output | 14 | Bytes still to post (zero when idle) |
| active | output | 1 | Engine running |
| overflow | output | 1 | Sticky dropped-push flag |
| fifo_ev_st | output | 1 | FIFO-space status |
| tc_ev_st | output | 1 | Terminal-count status |
| irq | output | 1 | Merged interrupt |

## Verification
The bound checker watches these rules on every clock:
- free space stays within range;
- the remaining count reads zero while idle and steps down by one per drained byte;
- the drain port is never valid while idle;
- completion sets the terminal-count status when enabled;
- both status bits stay sticky;
- an idle interrupt line follows clear status bits.

Some behaviour only the bench scenarios can show:
- the byte order across a full 64-byte run;
- a dropped overflow byte that never appears at the drain port;
- bytes left behind after a short count;
- a zero-count start that is ignored;
- a clear that has no effect while the threshold condition persists.

// File: rtl/wpost_pkg.sv
// Shared types for the write-posting engine.
package wpost_pkg;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/wpost_fifo.sv
// Byte FIFO for the posting path.
// Assumes: pop is only asserted while level is nonzero; a push into a full
// FIFO is dropped and recorded in a sticky overflow flag.
module wpost_fifo
    import wpost_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_valid,
    input  byte_t                         push_data,
    input  logic                          pop,
    input  logic                          ovf_clr,
    output byte_t                         pop_data,
    output logic [$clog2(DEPTH+1)-1:0]    level,
    output logic                          overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FW = $clog2(DEPTH + 1);
    localparam logic [FW-1:0] FULL_LVL = FW'(DEPTH);

    byte_t           mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic            full, push_ok;

    assign full    = (level == FULL_LVL);
    assign push_ok = push_valid && !full;
    assign pop_data = mem[rd_ptr];

    // Pointer advance: natural wrap for power-of-two depth, compare otherwise.
    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_nxt;
            if (pop)     rd_ptr <= rd_nxt;
            case ({push_ok, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Sticky record of dropped pushes.
    always_ff @(posedge clk) begin
        if (!rst_n)                   overflow <= 1'b0;
        else if (push_valid && full)  overflow <= 1'b1;
        else if (ovf_clr)             overflow <= 1'b0;
    end
endmodule

// File: rtl/wpost_counter.sv
// Run control: holds the active flag and the remaining-byte count.
// Assumes: fire is only asserted while active. The run ends on its own
// when the last counted byte leaves.
module wpost_counter #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] xfer_count,
    input  logic          fire,
    output logic          active,
    output logic [CW-1:0] remaining,
    output logic          start_acc,
    output logic          tc_pulse
);
    logic [CW-1:0] rem_q;

    assign start_acc = start && !active && (xfer_count != '0);
    assign tc_pulse  = active && fire && (rem_q == CW'(1));
    assign remaining = active ? rem_q : '0;

    // Load on start, count down per drained byte, self-stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            rem_q  <= '0;
        end else if (start_acc) begin
            active <= 1'b1;
            rem_q  <= xfer_count;
        end else if (active && fire) begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == CW'(1)) active <= 1'b0;
        end
    end
endmodule

// File: rtl/wpost_events.sv
// Sticky event status and merged interrupt.
// Assumes: a set condition in the same cycle as a clear wins.
module wpost_events (
    input  logic clk,
    input  logic rst_n,
    input  logic thresh_hit,
    input  logic fifo_ev_en,
    input  logic fifo_ev_clr,
    input  logic tc_pulse,
    input  logic tc_ev_en,
    input  logic tc_ev_clr,
    output logic fifo_ev_st,
    output logic tc_ev_st,
    output logic irq
);
    // FIFO-space status: set while enabled condition holds, else clearable.
    always_ff @(posedge clk) begin
        if (!rst_n)                        fifo_ev_st <= 1'b0;
        else if (fifo_ev_en && thresh_hit) fifo_ev_st <= 1'b1;
        else if (fifo_ev_clr)              fifo_ev_st <= 1'b0;
    end

    // Terminal-count status: set on automatic completion when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                   tc_ev_st <= 1'b0;
        else if (tc_pulse && tc_ev_en) tc_ev_st <= 1'b1;
        else if (tc_ev_clr)           tc_ev_st <= 1'b0;
    end

    // Merge enabled status bits.
    assign irq = (fifo_ev_st && fifo_ev_en) || (tc_ev_st && tc_ev_en);
endmodule

// File: rtl/wpost_engine.sv
// Write-posting engine top: host pushes bytes, engine drains them to the
// memory side while active, counting down a programmed transfer length.
// Assumes: one byte per push; drain handshake is ready/valid.
module wpost_engine
    import wpost_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = 14,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [7:0]    push_data,
    input  logic          start,
    input  logic [CW-1:0] xfer_count,
    input  logic [FW-1:0] thresh,
    input  logic          fifo_ev_en,
    input  logic          fifo_ev_clr,
    input  logic          tc_ev_en,
    input  logic          tc_ev_clr,
    input  logic          drain_ready,
    output logic          drain_valid,
    output logic [7:0]    drain_data,
    output logic [FW-1:0] free_slots,
    output logic          thresh_hit,
    output logic [CW-1:0] remaining,
    output logic          active,
    output logic          overflow,
    output logic          fifo_ev_st,
    output logic          tc_ev_st,
    output logic          irq
);
    localparam logic [FW-1:0] FULL_LVL = FW'(DEPTH);

    logic [FW-1:0] level;
    logic          fire, start_acc, tc_pulse;
    byte_t         pop_data;

    // Drain handshake and free-space reporting.
    assign drain_valid = active && (level != '0);
    assign fire        = drain_valid && drain_ready;
    assign drain_data  = pop_data;
    assign free_slots  = FULL_LVL - level;
    assign thresh_hit  = (free_slots >= thresh);

    wpost_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_data(push_data),
        .pop(fire), .ovf_clr(start_acc),
        .pop_data(pop_data), .level(level), .overflow(overflow)
    );

    wpost_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .start(start), .xfer_count(xfer_count), .fire(fire),
        .active(active), .remaining(remaining),
        .start_acc(start_acc), .tc_pulse(tc_pulse)
    );

    wpost_events u_ev (
        .clk(clk), .rst_n(rst_n),
        .thresh_hit(thresh_hit),
        .fifo_ev_en(fifo_ev_en), .fifo_ev_clr(fifo_ev_clr),
        .tc_pulse(tc_pulse), .tc_ev_en(tc_ev_en), .tc_ev_clr(tc_ev_clr),
        .fifo_ev_st(fifo_ev_st), .tc_ev_st(tc_ev_st), .irq(irq)
    );
endmodule

// File: rtl/wpost_engine_chk.sv
// Property checker for the write-posting engine, bound to every instance.
module wpost_engine_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 14,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          fifo_ev_en,
    input logic          fifo_ev_clr,
    input logic          tc_ev_en,
    input logic          tc_ev_clr,
    input logic          drain_ready,
    input logic          drain_valid,
    input logic [FW-1:0] free_slots,
    input logic [CW-1:0] remaining,
    input logic          active,
    input logic          overflow,
    input logic          fifo_ev_st,
    input logic          tc_ev_st,
    input logic          irq
);
    a_r1_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        free_slots <= FW'(DEPTH));

    a_r1_push_takes_slot: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && free_slots != '0 && !(drain_valid && drain_ready)
        |=> free_slots == $past(free_slots) - 1'b1);

    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && free_slots == '0 |=> overflow);

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> remaining == '0);

    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid && drain_ready && remaining > CW'(1)
        |=> remaining == $past(remaining) - 1'b1);

    a_r6_no_drain_idle: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |-> active);

    a_r7_self_stop: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid && drain_ready && remaining == CW'(1) |=> !active);

    a_r8_tc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid && drain_ready && remaining == CW'(1) && tc_ev_en |=> tc_ev_st);

    a_r8_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tc_ev_st && !tc_ev_clr |=> tc_ev_st);

    a_r9_fifo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ev_st && !fifo_ev_clr |=> fifo_ev_st);

    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_ev_st && !tc_ev_st |-> !irq);
endmodule

bind wpost_engine wpost_engine_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid),
    .fifo_ev_en(fifo_ev_en), .fifo_ev_clr(fifo_ev_clr),
    .tc_ev_en(tc_ev_en), .tc_ev_clr(tc_ev_clr),
    .drain_ready(drain_ready), .drain_valid(drain_valid),
    .free_slots(free_slots), .remaining(remaining), .active(active),
    .overflow(overflow), .fifo_ev_st(fifo_ev_st), .tc_ev_st(tc_ev_st),
    .irq(irq)
);

// File: tb/wpost_engine_bench.sv
// Self-checking bench for the write-posting engine.
module wpost_engine_bench;
    localparam int DEPTH = 64;
    localparam int CW    = 14;
    localparam int FW    = 7;

    typedef struct packed {
        logic [6:0] pushes;
        logic [6:0] thr;
        logic [6:0] exp_free;
        logic       exp_hit;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{pushes: 7'd0,  thr: 7'd64, exp_free: 7'd64, exp_hit: 1'b1},
        '{pushes: 7'd10, thr: 7'd55, exp_free: 7'd54, exp_hit: 1'b0},
        '{pushes: 7'd0,  thr: 7'd54, exp_free: 7'd54, exp_hit: 1'b1},
        '{pushes: 7'd30, thr: 7'd20, exp_free: 7'd24, exp_hit: 1'b1},
        '{pushes: 7'd24, thr: 7'd1,  exp_free: 7'd0,  exp_hit: 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic start = 1'b0;
    logic [CW-1:0] xfer_count = '0;
    logic [FW-1:0] thresh = '0;
    logic fifo_ev_en = 1'b0, fifo_ev_clr = 1'b0;
    logic tc_ev_en = 1'b0, tc_ev_clr = 1'b0;
    logic drain_ready = 1'b0;
    logic drain_valid;
    logic [7:0] drain_data;
    logic [FW-1:0] free_slots;
    logic thresh_hit;
    logic [CW-1:0] remaining;
    logic active, overflow, fifo_ev_st, tc_ev_st, irq;

    int n_chk = 0;
    int n_fail = 0;
    int got [128];
    int n_got;
    int seq = 0;

    always #5 clk = ~clk;

    wpost_engine #(.DEPTH(DEPTH), .CW(CW)) u_wpost_engine (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] d);
        push_valid = 1'b1;
        push_data  = d;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic do_start(input int cnt);
        xfer_count = CW'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_clr(input bit fifo, input bit tc);
        fifo_ev_clr = fifo;
        tc_ev_clr   = tc;
        @(negedge clk);
        fifo_ev_clr = 1'b0;
        tc_ev_clr   = 1'b0;
    endtask

    // Drains with ready high until the engine goes idle; records bytes.
    task automatic drain_run();
        n_got = 0;
        drain_ready = 1'b1;
        for (int i = 0; i < 300 && active; i++) begin
            if (drain_valid && n_got < 128) begin
                got[n_got] = drain_data;
                n_got++;
            end
            @(negedge clk);
        end
        drain_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        chk("R1 reset free", free_slots, 64);
        chk("R5 reset remaining", remaining, 0);
        chk("R4 reset active", active, 0);
        chk("R10 reset irq", irq, 0);

        // Table walk: fill while idle, check free space and threshold flag.
        foreach (VEC[i]) begin
            thresh = VEC[i].thr;
            for (int k = 0; k < int'(VEC[i].pushes); k++) begin
                push_byte(8'(seq));
                seq++;
            end
            @(negedge clk);
            chk("R1 table free", free_slots, int'(VEC[i].exp_free));
            chk("R2 table thresh_hit", thresh_hit, int'(VEC[i].exp_hit));
            chk("R6 idle no drain", drain_valid, 0);
        end

        // R3: push into full FIFO is dropped.
        push_byte(8'hFF);
        chk("R3 overflow set", overflow, 1);
        chk("R3 free stays 0", free_slots, 0);

        // R4/R3: start 64 clears overflow; tc disabled.
        do_start(64);
        chk("R4 active after start", active, 1);
        chk("R4 remaining loaded", remaining, 64);
        chk("R3 overflow cleared", overflow, 0);
        drain_run();
        chk("R6 bytes delivered", n_got, 64);
        bad = 0;
        for (int k = 0; k < 64; k++) if (got[k] != k) bad++;
        chk("R6 order and content", bad, 0);
        chk("R7 idle after run", active, 0);
        chk("R8 tc disabled stays clear", tc_ev_st, 0);
        chk("R1 empty after run", free_slots, 64);

        // Short count: 5 bytes, post 3.
        tc_ev_en = 1'b1;
        for (int k = 0; k < 5; k++) push_byte(8'(8'hA0 + k));
        do_start(3);
        chk("R4 remaining 3", remaining, 3);
        drain_ready = 1'b1;
        @(negedge clk);
        chk("R5 step down", remaining, 2);
        drain_ready = 1'b0;
        // Start while active ignored.
        do_start(9);
        chk("R4 start while active ignored", remaining, 2);
        drain_run();
        chk("R7 only counted bytes", n_got, 2);
        chk("R6 second byte", got[0], 8'hA1);
        chk("R7 leftover stays", free_slots, 62);
        chk("R5 idle remaining zero", remaining, 0);
        chk("R8 tc set", tc_ev_st, 1);
        chk("R10 irq from tc", irq, 1);
        pulse_clr(1'b0, 1'b1);
        chk("R8 tc cleared", tc_ev_st, 0);
        chk("R10 irq low", irq, 0);

        // Zero count ignored.
        do_start(0);
        chk("R4 zero count ignored", active, 0);

        // FIFO event: free 62, threshold 32.
        thresh = 7'd32;
        fifo_ev_en = 1'b1;
        @(negedge clk);
        chk("R9 fifo event set", fifo_ev_st, 1);
        chk("R10 irq from fifo event", irq, 1);
        pulse_clr(1'b1, 1'b0);
        chk("R9 clear ignored while hit", fifo_ev_st, 1);
        for (int k = 0; k < 40; k++) push_byte(8'(k));
        chk("R2 below thresh", thresh_hit, 0);
        pulse_clr(1'b1, 1'b0);
        chk("R9 cleared", fifo_ev_st, 0);
        @(negedge clk);
        chk("R9 stays clear", fifo_ev_st, 0);
        fifo_ev_en = 1'b0;
        chk("R10 irq quiet", irq, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule